// File: doc/BRIEF.md
# Wavefront Register Window Allocator

This block lets several shader wavefronts share one physical register file without their registers colliding. When a wavefront is launched into a slot, the block reserves a contiguous window of physical registers large enough for the wavefront's declared register count. Windows are handed out in chunks of four registers, and the block remembers where each window starts. Afterwards, every register access from that wavefront is turned into a physical address by adding the window start to the virtual register index the wavefront issues. The component (x, y, z or w) passes through as the bank select.

Admission control is the only policy here. A launch that cannot be given a window is refused in the same cycle, and the scheduler must try again later. Nothing is ever evicted or spilled. When a wavefront retires, its slot is freed and its chunks become available again. A free and an allocate can arrive in the same cycle; the free takes effect first. With the default parameters the file holds 256 registers split into 64 chunks, and 8 slots can be in use at once.

Top module: `wave_reg_window`

## Requirements
- R1: After reset no slot holds a window. A translate request for any slot raises `xlatErr` and returns address 0.
- R2: A granted request for N registers (1 to 128) reserves ceil(N/4) chunks of 4 registers. Virtual indices below 4*ceil(N/4) translate without error.
- R3: A grant places the window on the lowest-numbered chunk that begins a run of free chunks long enough for the request. `allocGrant` and the window start in registers (`allocBase`, always a multiple of 4) are driven combinationally in the cycle of the request. No granted window overlaps a window that is still held.
- R4: When no free run is long enough, `allocDeny` is raised in the same cycle. The table and the chunk map stay unchanged.
- R5: A request is also denied, and changes nothing, when the count is 0, when the count is above 128, or when the slot already holds a window that is not being freed in the same cycle.
- R6: For a valid translate request, `xlatAddr` = window start + `xlatVidx`. `xlatBank` always equals `xlatComp` (0 = x, 1 = y, 2 = z, 3 = w). Translation is combinational and reflects the table as it stood before the current clock edge.
- R7: `xlatErr` is raised, and `xlatAddr` is 0, when the slot holds no window or when `xlatVidx` is at or above the slot's rounded register count.
- R8: Freeing a slot that holds a window releases its chunks and invalidates the slot from the next cycle on. Freeing a slot that holds no window has no effect.
- R9: When a free and an allocate arrive in the same cycle, the free is applied first. The allocate may reuse the chunks just released and may reuse the same slot.
- R10: With the default sizes, two wavefronts of 128 registers each both fit: one window starts at register 0 and the other at register 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocReq | input | 1 | Request a window for a launching wavefront |
| allocSlot | input | 3 | Slot the wavefront launches into |
| allocCount | input | 8 | Declared register count |
| allocGrant | output | 1 | Request accepted this cycle |
| allocDeny | output | 1 | Request refused this cycle |
| allocBase | output | 8 | Window start register, valid with allocGrant |
| freeReq | input | 1 | Retire the wavefront in freeSlot |
| freeSlot | input | 3 | Slot to release |
| xlatSlot | input | 3 | Slot issuing a register access |
| xlatVidx | input | 7 | Virtual register index |
| xlatComp | input | 2 | Register component (0 x, 1 y, 2 z, 3 w) |
| xlatAddr | output | 8 | Physical register index |
| xlatBank | output | 2 | Component bank select |
| xlatErr | output | 1 | Slot holds no window, or index out of range |

## Verification
Directed sequences check three placement behaviours. Small odd counts check the round-up. A maximum-size request that fits check, kept apart from one that falls short by two chunks, checks refusal on a full file. A free followed by a smaller allocation checks that first-fit reuses a hole at the bottom of the file instead of always appending. Same-cycle free and allocate on the same slot, and on different slots, show whether the release is ordered first. Translate probes sit exactly at and one below each window's rounded limit, which catches off-by-one bounds and round-up errors. A long stretch of random allocate, free and translate traffic is then compared every cycle against a behavioural model. This stretch exposes fragmentation cases and stale-table reads that the directed cases do not reach.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int GRAN_REGS = 4;

  typedef enum logic [1:0] {
    COMP_X = 2'd0,
    COMP_Y = 2'd1,
    COMP_Z = 2'd2,
    COMP_W = 2'd3
  } regComp_t;

  typedef struct packed {
    logic doFree;
    logic doAlloc;
  } rwStrobe_t;
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int PHYS_REGS = 256,
  parameter int MAX_VREGS = 128,
  localparam int G   = PHYS_REGS / GRAN_REGS,
  localparam int GW  = $clog2(G),
  localparam int LW  = $clog2(MAX_VREGS / GRAN_REGS + 1),
  localparam int CW  = $clog2(MAX_VREGS + 1),
  localparam int SW  = $clog2(NUM_SLOTS)
) (
  input  logic                 allocReq,
  input  logic [SW-1:0]        allocSlot,
  input  logic [CW-1:0]        allocCount,
  input  logic                 freeReq,
  input  logic [SW-1:0]        freeSlot,
  input  logic [NUM_SLOTS-1:0] slotValid,
  input  logic [G-1:0]         occ,
  input  logic [G-1:0]         relMask,
  output rwStrobe_t            strobe,
  output logic [GW-1:0]        allocGran,
  output logic [LW-1:0]        allocLen,
  output logic                 allocGrant,
  output logic                 allocDeny
);
  logic          freeNow;
  logic [G-1:0]  effOcc;
  logic [LW-1:0] needG;
  logic          countOk;
  logic          slotBusy;
  logic          found;
  logic [GW-1:0] pos;
  logic [GW:0]   run [G+1];

  assign freeNow  = freeReq && slotValid[freeSlot];
  // release ahead of allocation: search the map as it will be after the free
  assign effOcc   = occ & ~(freeNow ? relMask : '0);
  assign countOk  = (allocCount != '0) && (int'(allocCount) <= MAX_VREGS);
  assign slotBusy = slotValid[allocSlot] && !(freeNow && (freeSlot == allocSlot));

  always_comb begin
    needG = LW'((int'(allocCount) + GRAN_REGS - 1) / GRAN_REGS);
  end

  // free-run length starting at each chunk, built from the top down
  always_comb begin
    run[G] = '0;
    for (int i = G - 1; i >= 0; i--) begin
      run[i] = effOcc[i] ? '0 : run[i+1] + 1'b1;
    end
  end

  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = 0; i < G; i++) begin
      if (!found && (int'(run[i]) >= int'(needG))) begin
        found = 1'b1;
        pos   = GW'(i);
      end
    end
  end

  assign allocGrant     = allocReq && countOk && !slotBusy && found;
  assign allocDeny      = allocReq && !allocGrant;
  assign allocGran      = pos;
  assign allocLen       = needG;
  assign strobe.doFree  = freeNow;
  assign strobe.doAlloc = allocGrant;
endmodule

// File: rtl/regwin_dpath.sv
module regwin_dpath
  import regwin_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int PHYS_REGS = 256,
  parameter int MAX_VREGS = 128,
  localparam int G   = PHYS_REGS / GRAN_REGS,
  localparam int GW  = $clog2(G),
  localparam int LW  = $clog2(MAX_VREGS / GRAN_REGS + 1),
  localparam int VW  = $clog2(MAX_VREGS),
  localparam int PW  = $clog2(PHYS_REGS),
  localparam int SW  = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rwStrobe_t            strobe,
  input  logic [SW-1:0]        freeSlot,
  input  logic [SW-1:0]        allocSlot,
  input  logic [GW-1:0]        allocGran,
  input  logic [LW-1:0]        allocLen,
  input  logic [SW-1:0]        xlatSlot,
  input  logic [VW-1:0]        xlatVidx,
  input  regComp_t             xlatComp,
  output logic [NUM_SLOTS-1:0] slotValid,
  output logic [G-1:0]         occ,
  output logic [G-1:0]         relMask,
  output logic [PW-1:0]        xlatAddr,
  output regComp_t             xlatBank,
  output logic                 xlatErr
);
  logic [GW-1:0] baseG [NUM_SLOTS];
  logic [LW-1:0] lenG  [NUM_SLOTS];
  logic [G-1:0]  allocMask;

  function automatic logic [G-1:0] spanMask(input logic [GW-1:0] b, input logic [LW-1:0] n);
    logic [G-1:0] m;
    for (int g = 0; g < G; g++) begin
      m[g] = (g >= int'(b)) && (g < int'(b) + int'(n));
    end
    return m;
  endfunction

  assign relMask   = spanMask(baseG[freeSlot], lenG[freeSlot]);
  assign allocMask = spanMask(allocGran, allocLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      occ       <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        baseG[s] <= '0;
        lenG[s]  <= '0;
      end
    end else begin
      if (strobe.doFree) slotValid[freeSlot] <= 1'b0;
      if (strobe.doAlloc) begin
        slotValid[allocSlot] <= 1'b1;
        baseG[allocSlot]     <= allocGran;
        lenG[allocSlot]      <= allocLen;
      end
      occ <= (occ & ~(strobe.doFree ? relMask : '0)) | (strobe.doAlloc ? allocMask : '0);
    end
  end

  always_comb begin
    xlatErr  = !slotValid[xlatSlot] ||
               (int'(xlatVidx) >= int'(lenG[xlatSlot]) * GRAN_REGS);
    xlatAddr = xlatErr ? '0 :
               PW'(int'(baseG[xlatSlot]) * GRAN_REGS + int'(xlatVidx));
    xlatBank = xlatComp;
  end

  int occSum;
  always_comb begin
    occSum = 0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slotValid[s]) occSum += int'(lenG[s]);
    end
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAlloc |-> ((allocMask & occ & ~(strobe.doFree ? relMask : '0)) == '0));

  assert_slot_live_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAlloc |=> slotValid[$past(allocSlot)]);

  assert_free_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doFree && !(strobe.doAlloc && (allocSlot == freeSlot)))
      |=> !slotValid[$past(freeSlot)]);

  assert_occ_tally_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(occ) == occSum);
endmodule

// File: rtl/wave_reg_window.sv
module wave_reg_window
  import regwin_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int PHYS_REGS = 256,
  parameter int MAX_VREGS = 128,
  localparam int G   = PHYS_REGS / GRAN_REGS,
  localparam int GW  = $clog2(G),
  localparam int LW  = $clog2(MAX_VREGS / GRAN_REGS + 1),
  localparam int CW  = $clog2(MAX_VREGS + 1),
  localparam int VW  = $clog2(MAX_VREGS),
  localparam int PW  = $clog2(PHYS_REGS),
  localparam int SW  = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          allocReq,
  input  logic [SW-1:0] allocSlot,
  input  logic [CW-1:0] allocCount,
  output logic          allocGrant,
  output logic          allocDeny,
  output logic [PW-1:0] allocBase,
  input  logic          freeReq,
  input  logic [SW-1:0] freeSlot,
  input  logic [SW-1:0] xlatSlot,
  input  logic [VW-1:0] xlatVidx,
  input  logic [1:0]    xlatComp,
  output logic [PW-1:0] xlatAddr,
  output logic [1:0]    xlatBank,
  output logic          xlatErr
);
  rwStrobe_t            strobe;
  logic [NUM_SLOTS-1:0] slotValid;
  logic [G-1:0]         occ;
  logic [G-1:0]         relMask;
  logic [GW-1:0]        allocGran;
  logic [LW-1:0]        allocLen;
  regComp_t             bankSel;

  regwin_ctrl #(.NUM_SLOTS(NUM_SLOTS), .PHYS_REGS(PHYS_REGS), .MAX_VREGS(MAX_VREGS)) uCtrl (
    .allocReq(allocReq), .allocSlot(allocSlot), .allocCount(allocCount),
    .freeReq(freeReq), .freeSlot(freeSlot), .slotValid(slotValid),
    .occ(occ), .relMask(relMask), .strobe(strobe),
    .allocGran(allocGran), .allocLen(allocLen),
    .allocGrant(allocGrant), .allocDeny(allocDeny)
  );

  regwin_dpath #(.NUM_SLOTS(NUM_SLOTS), .PHYS_REGS(PHYS_REGS), .MAX_VREGS(MAX_VREGS)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .freeSlot(freeSlot), .allocSlot(allocSlot),
    .allocGran(allocGran), .allocLen(allocLen),
    .xlatSlot(xlatSlot), .xlatVidx(xlatVidx), .xlatComp(regComp_t'(xlatComp)),
    .slotValid(slotValid), .occ(occ), .relMask(relMask),
    .xlatAddr(xlatAddr), .xlatBank(bankSel), .xlatErr(xlatErr)
  );

  assign allocBase = PW'(int'(allocGran) * GRAN_REGS);
  assign xlatBank  = bankSel;
endmodule

// File: tb/tb_wave_reg_window.sv
`timescale 1ns/1ps
module tb_wave_reg_window;
  localparam int NS = 8;
  localparam int NG = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocReq = 1'b0, freeReq = 1'b0;
  logic [2:0] allocSlot = '0, freeSlot = '0, xlatSlot = '0;
  logic [7:0] allocCount = '0;
  logic [6:0] xlatVidx = '0;
  logic [1:0] xlatComp = '0;
  logic allocGrant, allocDeny, xlatErr;
  logic [7:0] allocBase, xlatAddr;
  logic [1:0] xlatBank;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  int refValid [NS];
  int refBase  [NS];
  int refLen   [NS];
  int refOcc   [NG];

  always #2.5 clk = ~clk;

  wave_reg_window dut (
    .clk(clk), .rstN(rstN),
    .allocReq(allocReq), .allocSlot(allocSlot), .allocCount(allocCount),
    .allocGrant(allocGrant), .allocDeny(allocDeny), .allocBase(allocBase),
    .freeReq(freeReq), .freeSlot(freeSlot),
    .xlatSlot(xlatSlot), .xlatVidx(xlatVidx), .xlatComp(xlatComp),
    .xlatAddr(xlatAddr), .xlatBank(xlatBank), .xlatErr(xlatErr)
  );

  // one cycle: drive at negedge, compare against the model, advance the model
  task automatic step(input bit aReq, input int aSlot, input int aCnt,
                      input bit fReq, input int fSlot,
                      input int xs, input int xi, input int xc, input string tag);
    int eff [NG];
    bit fNow, ok, expGrant, expErr, bad;
    int need, fit, expBase, expAddr;
    allocReq = aReq; allocSlot = aSlot[2:0]; allocCount = aCnt[7:0];
    freeReq = fReq; freeSlot = fSlot[2:0];
    xlatSlot = xs[2:0]; xlatVidx = xi[6:0]; xlatComp = xc[1:0];
    #1;
    fNow = fReq && (refValid[fSlot] != 0);
    for (int g = 0; g < NG; g++) eff[g] = refOcc[g];
    if (fNow) for (int g = refBase[fSlot]; g < refBase[fSlot] + refLen[fSlot]; g++) eff[g] = 0;
    need = (aCnt + 3) / 4;
    ok = aReq && aCnt >= 1 && aCnt <= 128 && !((refValid[aSlot] != 0) && !(fNow && fSlot == aSlot));
    fit = -1;
    if (ok) begin
      for (int s = 0; s + need <= NG; s++) begin
        bit clear = 1;
        for (int k = 0; k < need; k++) if (eff[s+k] != 0) clear = 0;
        if (clear && fit < 0) fit = s;
      end
    end
    expGrant = ok && fit >= 0;
    expBase  = expGrant ? fit * 4 : 0;
    expErr   = (refValid[xs] == 0) || (xi >= refLen[xs] * 4);
    expAddr  = expErr ? 0 : refBase[xs] * 4 + xi;

    bad = (allocGrant !== expGrant) || (allocDeny !== (aReq && !expGrant)) ||
          (expGrant && allocBase !== expBase[7:0]) ||
          (xlatErr !== expErr) || (xlatAddr !== expAddr[7:0]) || (xlatBank !== xc[1:0]);
    vectors++;
    if (bad) begin
      miscompares++;
      $display("FAIL %s: grant=%0b deny=%0b base=%0d err=%0b addr=%0d bank=%0d expected grant=%0b deny=%0b base=%0d err=%0b addr=%0d bank=%0d",
               tag, allocGrant, allocDeny, allocBase, xlatErr, xlatAddr, xlatBank,
               expGrant, aReq && !expGrant, expBase, expErr, expAddr, xc);
    end

    if (fNow) begin
      for (int g = 0; g < NG; g++) refOcc[g] = eff[g];
      refValid[fSlot] = 0;
    end
    if (expGrant) begin
      refValid[aSlot] = 1; refBase[aSlot] = fit; refLen[aSlot] = need;
      for (int g = fit; g < fit + need; g++) refOcc[g] = 1;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NS; s++) begin refValid[s] = 0; refBase[s] = 0; refLen[s] = 0; end
    for (int g = 0; g < NG; g++) refOcc[g] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, every slot empty
    for (int s = 0; s < NS; s++) step(0, 0, 0, 0, 0, s, 0, s % 4, "R1");
    // R2/R3: 5 registers rounds to 8, first fit at register 0
    step(1, 0, 5, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 7, 1, "R2");
    step(0, 0, 0, 0, 0, 0, 8, 2, "R7");
    // R10/R3: 128 registers lands right after, at register 8
    step(1, 1, 128, 0, 0, 1, 127, 3, "R10");
    step(0, 0, 0, 0, 0, 1, 127, 3, "R6");
    step(0, 0, 0, 0, 0, 1, 0, 2, "R6");
    // R4: only 30 chunks remain, 32 needed
    step(1, 2, 128, 0, 0, 2, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 2, 0, 0, "R4");
    // R5: busy slot, zero count, oversized count
    step(1, 0, 4, 0, 0, 0, 4, 0, "R5");
    step(1, 3, 0, 0, 0, 3, 0, 0, "R5");
    step(1, 3, 129, 0, 0, 3, 0, 0, "R5");
    // R8: free slot 0, then a smaller request reuses the bottom hole
    step(0, 0, 0, 1, 0, 0, 0, 0, "R8");
    step(1, 3, 8, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 5, 3, 7, 1, "R8");
    step(0, 0, 0, 0, 0, 5, 0, 0, "R8");
    // R9: same-slot release and re-grant in one cycle
    step(1, 1, 128, 1, 1, 1, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 127, 1, "R9");
    // R9: release slot 3 and grant slot 4 into its chunks
    step(1, 4, 6, 1, 3, 3, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 4, 7, 3, "R9");
    // R10: empty the file, then two maximum windows at 0 and 128
    step(0, 0, 0, 1, 1, 0, 0, 0, "R10");
    step(0, 0, 0, 1, 4, 0, 0, 0, "R10");
    step(1, 6, 128, 0, 0, 0, 0, 0, "R10");
    step(1, 7, 128, 0, 0, 6, 127, 2, "R10");
    step(0, 0, 0, 0, 0, 7, 127, 3, "R10");
    step(0, 0, 0, 1, 6, 7, 0, 0, "R8");
    step(0, 0, 0, 1, 7, 0, 0, 0, "R8");

    // R3: random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int c;
      c = ($urandom % 4 == 0) ? ($urandom % 140) : (1 + $urandom % 40);
      step($urandom % 2 == 0, $urandom % NS, c, $urandom % 3 == 0, $urandom % NS,
           $urandom % NS, $urandom % 128, $urandom % 4, "R3");
    end
    finish_run();
  end
endmodule